// File: doc/BRIEF.md
# Memory Bit-Field Access Unit

This unit carries out a single bit-field operation on byte-addressed, big-endian memory. A command supplies a base byte address, a signed bit offset, an encoded field length and an operation. The unit finds the first byte that the field touches and the number of bytes it covers. It fetches those bytes one at a time through a byte-wide memory port and applies the operation to a local window. For the operations that modify memory, it then stores the covered bytes back. When the command completes, the unit returns a 32-bit result and the most significant bit of the original field. That bit is the negative flag.

The field may begin before the base byte when the offset is negative. An encoded length of zero selects a full 32-bit field, and such a field can cover as many as five bytes. Seven operations are supported: unsigned extract, signed extract, insert, change, clear, set and find-first-one. The unit accepts one command at a time. A new command can be accepted in the same cycle that the previous command reports completion.

Top module: `bfu_top`

## Requirements
- R1: An encoded length `cmd_len` of 0 selects a 32-bit field. Any other value L selects an L-bit field.
- R2: The first byte touched is `cmd_base + floor(cmd_ofs / 8)` and the starting bit within it is `cmd_ofs mod 8`, taken as non-negative. A negative offset therefore reaches bytes below the base.
- R3: The number of bytes read is `floor((bit + length - 1) / 8) + 1`, which ranges from 1 to 5. The reads start at the first touched byte and proceed in ascending address order.
- R4: Field bit 0 is bit 7, the most significant bit, of the first touched byte. The field then continues through following bits and bytes in big-endian order.
- R5: Unsigned extract (`cmd_op` = 0) returns the field zero-extended to 32 bits. Signed extract (`cmd_op` = 1) returns it sign-extended from the field's top bit.
- R6: Insert (`cmd_op` = 2) replaces the field with the low `length` bits of `cmd_val` and leaves every other bit unchanged. Its result is those value bits left-aligned in 32 bits.
- R7: Change (3), clear (4) and set (5) invert, zero or set the field bits respectively. Each returns the old field contents left-aligned in 32 bits.
- R8: Find-first-one (`cmd_op` = 6) returns `cmd_ofs` plus the number of leading zero bits in the field. If the field is entirely zero, it returns `cmd_ofs` plus the length.
- R9: Extract and find-first-one issue no writes. The modifying operations write exactly the bytes that were read, in ascending order, and only after all reads are complete.
- R10: `res_n` equals the most significant bit of the field as it was before the operation.
- R11: After reset, `cmd_ready` is 1, `done` is 0 and `mem_valid` is 0. `cmd_ready` is 1 only while idle, and `done` is a one-cycle pulse. A command presented in the cycle where `done` is 1 is accepted.
- R12: While `mem_valid` is 1 and `mem_ready` is 0, the unit holds `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Unit idle; a command is taken when cmd_valid and cmd_ready are both 1 |
| cmd_op | input | 3 | Operation code (see R5 to R8) |
| cmd_base | input | AW (32) | Base byte address |
| cmd_ofs | input | FW (32) | Signed bit offset |
| cmd_len | input | 5 | Encoded field length, 0 means 32 |
| cmd_val | input | FW (32) | Value for insert |
| done | output | 1 | One-cycle completion pulse |
| res | output | FW (32) | Result, held from done until the next completion |
| res_n | output | 1 | Top bit of the original field |
| mem_valid | output | 1 | Memory request |
| mem_write | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW (32) | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, taken in the cycle mem_ready is 1 |
| mem_ready | input | 1 | Memory accepts the request this cycle |

## Verification
Two events can fall in the same cycle. One is the completion pulse of a command. The other is the acceptance of the next command, because `cmd_ready` is already 1 while `done` is 1. The bench provokes this by presenting a second command at the exact moment the first reports `done`. The overlap is judged correct when the unit is busy on the following cycle with `done` low, and when both commands deliver their own result and memory image. The second command must see the bytes written by the first. Stalled memory cycles are also mixed in, so that request holding overlaps with the byte ordering rules.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

   typedef enum logic [2:0] {
      OP_EXTU = 3'd0,
      OP_EXTS = 3'd1,
      OP_INS  = 3'd2,
      OP_CHG  = 3'd3,
      OP_CLR  = 3'd4,
      OP_SET  = 3'd5,
      OP_FFO  = 3'd6
   } bfu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_EXEC  = 2'd2,
      ST_WRITE = 2'd3
   } bfu_state_e;

   function automatic logic op_modifies(input bfu_op_e op);
      return (op == OP_INS) || (op == OP_CHG) || (op == OP_CLR) || (op == OP_SET);
   endfunction

endpackage

// File: rtl/bfu_prep.sv
module bfu_prep #(
   parameter int AW = 32,
   parameter int FW = 32
) (
   input  logic [AW-1:0]             base,
   input  logic [FW-1:0]             ofs,
   input  logic [$clog2(FW)-1:0]     len,
   output logic [AW-1:0]             start_addr,
   output logic [2:0]                bit_pos,
   output logic [$clog2(FW):0]       eff_len,
   output logic [$clog2(FW/8+1)-1:0] span_m1
);
   localparam int LW   = $clog2(FW);
   localparam int LENW = LW + 1;
   localparam int NB   = FW / 8 + 1;
   localparam int SPW  = $clog2(NB);

   logic signed [FW-1:0] byte_step;
   logic signed [AW-1:0] step_ext;
   logic [LENW:0]        last_bit;

   // floor division by 8 through an arithmetic shift
   assign byte_step  = $signed(ofs) >>> 3;
   assign step_ext   = AW'(byte_step);
   assign start_addr = base + $unsigned(step_ext);
   assign bit_pos    = ofs[2:0];

   assign eff_len  = (len == '0) ? LENW'(FW) : {1'b0, len};
   assign last_bit = (LENW+1)'(bit_pos) + (LENW+1)'(eff_len) - (LENW+1)'(1);
   assign span_m1  = SPW'(last_bit >> 3);

endmodule

// File: rtl/bfu_lz.sv
module bfu_lz #(
   parameter int FW = 32
) (
   input  logic [FW-1:0]         word,
   output logic [$clog2(FW):0]   lead,
   output logic                  all_zero
);
   localparam int LENW = $clog2(FW) + 1;

   always_comb begin
      lead = LENW'(FW);
      for (int i = 0; i < FW; i++) begin
         if (word[i]) lead = LENW'(FW - 1 - i);
      end
   end

   assign all_zero = (word == '0);

endmodule

// File: rtl/bfu_alu.sv
module bfu_alu
   import bfu_pkg::*;
#(
   parameter int FW = 32
) (
   input  logic [(FW/8+1)*8-1:0] win,
   input  bfu_op_e               op,
   input  logic [2:0]            bit_pos,
   input  logic [$clog2(FW):0]   eff_len,
   input  logic [FW-1:0]         val,
   input  logic [FW-1:0]         ofs,
   output logic [(FW/8+1)*8-1:0] new_win,
   output logic [FW-1:0]         result,
   output logic                  top_bit
);
   localparam int LENW = $clog2(FW) + 1;
   localparam int NB   = FW / 8 + 1;
   localparam int WW   = NB * 8;

   logic [LENW-1:0] shamt;
   logic [FW-1:0]   top_mask;
   logic [WW-1:0]   aligned;
   logic [FW-1:0]   old_field;
   logic [WW-1:0]   field_mask;
   logic [FW-1:0]   ins_left;
   logic [WW-1:0]   ins_win;
   logic [LENW-1:0] lead;
   logic            all_zero;

   assign shamt      = LENW'(FW) - eff_len;
   assign top_mask   = ~({FW{1'b1}} >> eff_len);
   assign aligned    = win << bit_pos;
   assign old_field  = aligned[WW-1 -: FW] & top_mask;
   assign field_mask = {top_mask, {(WW-FW){1'b0}}} >> bit_pos;
   assign ins_left   = val << shamt;
   assign ins_win    = {ins_left, {(WW-FW){1'b0}}} >> bit_pos;
   assign top_bit    = old_field[FW-1];

   bfu_lz #(.FW(FW)) u_lz (
      .word     (old_field),
      .lead     (lead),
      .all_zero (all_zero)
   );

   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic [7:0] m;
      logic [7:0] d;
      logic [7:0] s;
      assign m = field_mask[b*8 +: 8];
      assign d = win[b*8 +: 8];
      assign s = ins_win[b*8 +: 8];
      always_comb begin
         unique case (op)
            OP_INS:  new_win[b*8 +: 8] = (d & ~m) | (s & m);
            OP_CHG:  new_win[b*8 +: 8] = d ^ m;
            OP_CLR:  new_win[b*8 +: 8] = d & ~m;
            OP_SET:  new_win[b*8 +: 8] = d | m;
            default: new_win[b*8 +: 8] = d;
         endcase
      end
   end

   always_comb begin
      unique case (op)
         OP_EXTS: result = FW'($signed(old_field) >>> shamt);
         OP_INS:  result = ins_left;
         OP_CHG,
         OP_CLR,
         OP_SET:  result = old_field;
         OP_FFO:  result = ofs + FW'(all_zero ? eff_len : lead);
         default: result = old_field >> shamt;
      endcase
   end

endmodule

// File: rtl/bfu_top.sv
module bfu_top
   import bfu_pkg::*;
#(
   parameter int AW = 32,
   parameter int FW = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   output logic                  cmd_ready,
   input  logic [2:0]            cmd_op,
   input  logic [AW-1:0]         cmd_base,
   input  logic [FW-1:0]         cmd_ofs,
   input  logic [$clog2(FW)-1:0] cmd_len,
   input  logic [FW-1:0]         cmd_val,
   output logic                  done,
   output logic [FW-1:0]         res,
   output logic                  res_n,
   output logic                  mem_valid,
   output logic                  mem_write,
   output logic [AW-1:0]         mem_addr,
   output logic [7:0]            mem_wdata,
   input  logic [7:0]            mem_rdata,
   input  logic                  mem_ready
);
   localparam int LW   = $clog2(FW);
   localparam int LENW = LW + 1;
   localparam int NB   = FW / 8 + 1;
   localparam int SPW  = $clog2(NB);

   if (FW < 8 || (FW & (FW - 1)) != 0) begin : g_bad_fw
      $error("bfu_top: FW must be a power of two of at least 8");
   end
   if (AW < FW) begin : g_bad_aw
      $error("bfu_top: AW must not be narrower than FW");
   end

   bfu_state_e            state;
   logic [SPW-1:0]        idx;
   logic [SPW-1:0]        span_q;
   logic [AW-1:0]         addr_q;
   logic [2:0]            bit_q;
   logic [LENW-1:0]       elen_q;
   bfu_op_e               op_q;
   logic [FW-1:0]         val_q;
   logic [FW-1:0]         ofs_q;
   logic [NB-1:0][7:0]    win_q;
   logic [FW-1:0]         res_q;
   logic                  n_q;
   logic                  done_q;

   logic [AW-1:0]         p_addr;
   logic [2:0]            p_bit;
   logic [LENW-1:0]       p_elen;
   logic [SPW-1:0]        p_span;
   logic [NB*8-1:0]       alu_win;
   logic [FW-1:0]         alu_res;
   logic                  alu_n;
   logic                  cmd_fire;
   logic                  xfer;
   logic [SPW-1:0]        lane;

   bfu_prep #(.AW(AW), .FW(FW)) u_prep (
      .base       (cmd_base),
      .ofs        (cmd_ofs),
      .len        (cmd_len),
      .start_addr (p_addr),
      .bit_pos    (p_bit),
      .eff_len    (p_elen),
      .span_m1    (p_span)
   );

   bfu_alu #(.FW(FW)) u_alu (
      .win     (win_q),
      .op      (op_q),
      .bit_pos (bit_q),
      .eff_len (elen_q),
      .val     (val_q),
      .ofs     (ofs_q),
      .new_win (alu_win),
      .result  (alu_res),
      .top_bit (alu_n)
   );

   assign cmd_ready = (state == ST_IDLE);
   assign cmd_fire  = cmd_valid && cmd_ready;
   assign mem_valid = (state == ST_READ) || (state == ST_WRITE);
   assign mem_write = (state == ST_WRITE);
   assign mem_addr  = addr_q + AW'(idx);
   assign lane      = SPW'(NB - 1) - idx;
   assign mem_wdata = win_q[lane];
   assign xfer      = mem_valid && mem_ready;
   assign done      = done_q;
   assign res       = res_q;
   assign res_n     = n_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         span_q <= '0;
         addr_q <= '0;
         bit_q  <= '0;
         elen_q <= '0;
         op_q   <= OP_EXTU;
         val_q  <= '0;
         ofs_q  <= '0;
         win_q  <= '0;
         res_q  <= '0;
         n_q    <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (cmd_fire) begin
                  state  <= ST_READ;
                  idx    <= '0;
                  span_q <= p_span;
                  addr_q <= p_addr;
                  bit_q  <= p_bit;
                  elen_q <= p_elen;
                  op_q   <= bfu_op_e'(cmd_op);
                  val_q  <= cmd_val;
                  ofs_q  <= cmd_ofs;
                  win_q  <= '0;
               end
            end
            ST_READ: begin
               if (xfer) begin
                  win_q[lane] <= mem_rdata;
                  if (idx == span_q) begin
                     state <= ST_EXEC;
                     idx   <= '0;
                  end else begin
                     idx <= idx + SPW'(1);
                  end
               end
            end
            ST_EXEC: begin
               win_q <= alu_win;
               res_q <= alu_res;
               n_q   <= alu_n;
               if (op_modifies(op_q)) begin
                  state <= ST_WRITE;
               end else begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            ST_WRITE: begin
               if (xfer) begin
                  if (idx == span_q) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     idx <= idx + SPW'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R12

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

   AST_WRITE_ONLY_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_write |-> op_modifies(op_q)); // R9

   AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_fire |-> p_span <= SPW'(NB - 1)); // R3

   AST_FFO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC) && (op_q == OP_FFO) |-> (alu_res - ofs_q) <= FW'(elen_q)); // R8

   AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC) && (op_q == OP_EXTS) |-> alu_res[FW-1] == alu_n); // R10

endmodule

// File: tb/sim_bfu_top.sv
module sim_bfu_top;
   import bfu_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [2:0]  cmd_op = 3'd0;
   logic [31:0] cmd_base = 32'd0;
   logic [31:0] cmd_ofs = 32'd0;
   logic [4:0]  cmd_len = 5'd0;
   logic [31:0] cmd_val = 32'd0;
   logic        done;
   logic [31:0] res;
   logic        res_n;
   logic        mem_valid;
   logic        mem_write;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        mem_ready;

   always #5 clk = ~clk;

   bfu_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_op    (cmd_op),
      .cmd_base  (cmd_base),
      .cmd_ofs   (cmd_ofs),
      .cmd_len   (cmd_len),
      .cmd_val   (cmd_val),
      .done      (done),
      .res       (res),
      .res_n     (res_n),
      .mem_valid (mem_valid),
      .mem_write (mem_write),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready)
   );

   // byte memory model with optional stalls
   logic [7:0] mem [0:63];
   logic [7:0] exp_mem [0:63];
   logic       stall_en = 1'b0;
   logic       tick = 1'b0;

   always @(posedge clk) begin
      tick <= ~tick;
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 37 + 11);
      end else if (mem_valid && mem_ready && mem_write) begin
         mem[mem_addr[5:0]] <= mem_wdata;
      end
   end
   assign mem_ready = !stall_en || tick;
   assign mem_rdata = mem[mem_addr[5:0]];

   // port monitor
   int op_rd = 0, op_wr = 0, op_first = 0, ord_err = 0, hold_err = 0;
   int last_addr = 0;
   logic pend = 1'b0;
   logic [31:0] pend_addr = 0;
   logic pend_wr = 1'b0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (pend && (!mem_valid || mem_addr != pend_addr || mem_write != pend_wr)) hold_err++;
         pend = mem_valid && !mem_ready;
         pend_addr = mem_addr;
         pend_wr = mem_write;
         if (cmd_valid && cmd_ready) begin
            op_rd = 0;
            op_wr = 0;
         end else if (mem_valid && mem_ready) begin
            if (mem_write) begin
               if (op_wr == 0) begin
                  if (op_rd == 0 || int'(mem_addr) != op_first) ord_err++;
               end else if (int'(mem_addr) != last_addr + 1) ord_err++;
               op_wr++;
            end else begin
               if (op_wr != 0) ord_err++;
               if (op_rd == 0) op_first = int'(mem_addr);
               else if (int'(mem_addr) != last_addr + 1) ord_err++;
               op_rd++;
            end
            last_addr = int'(mem_addr);
         end
      end
   end

   int n_checks = 0;
   int n_errs = 0;
   int cyc = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_errs++;
         $display("FAIL R11 watchdog act=hung exp=done");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // expectations
   logic [31:0] exp_res;
   logic        exp_n;
   int          exp_rd, exp_wr, exp_first;
   int          ord_base, hold_base;

   function automatic logic rbit(input int g);
      return exp_mem[g >> 3][7 - (g & 7)];
   endfunction

   task automatic prepare(input logic [2:0] op, input int base, input int ofs,
                          input int len, input logic [31:0] val);
      int g0, L, first;
      logic [63:0] f;
      L = (len == 0) ? 32 : len;
      g0 = base * 8 + ofs;
      for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
      f = 64'd0;
      for (int i = 0; i < L; i++) f = (f << 1) | 64'(rbit(g0 + i));
      exp_n = rbit(g0);
      first = L;
      for (int i = L - 1; i >= 0; i--) if (rbit(g0 + i)) first = i;
      case (op)
         OP_EXTU: exp_res = f[31:0];
         OP_EXTS: exp_res = f[L-1] ? 32'(f | (~64'd0 << L)) : f[31:0];
         OP_INS:  exp_res = 32'(64'(val) << (32 - L));
         OP_FFO:  exp_res = 32'(ofs + first);
         default: exp_res = 32'(f << (32 - L));
      endcase
      for (int i = 0; i < L; i++) begin
         int g;
         logic b;
         g = g0 + i;
         b = rbit(g);
         case (op)
            OP_INS: b = val[L-1-i];
            OP_CHG: b = ~b;
            OP_CLR: b = 1'b0;
            OP_SET: b = 1'b1;
            default: ;
         endcase
         exp_mem[g >> 3][7 - (g & 7)] = b;
      end
      exp_first = g0 / 8;
      exp_rd = (g0 + L - 1) / 8 - g0 / 8 + 1;
      exp_wr = op_modifies(bfu_op_e'(op)) ? exp_rd : 0;
   endtask

   task automatic issue(input logic [2:0] op, input int base, input int ofs,
                        input int len, input logic [31:0] val);
      prepare(op, base, ofs, len, val);
      ord_base = ord_err;
      hold_base = hold_err;
      cmd_op = op;
      cmd_base = 32'(base);
      cmd_ofs = 32'(ofs);
      cmd_len = 5'(len);
      cmd_val = val;
      cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic finish_op(input string tag);
      int t;
      int bad;
      t = 0;
      while (!done && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk("R11 done", 32'(done), 32'd1);
      chk(tag, res, exp_res);
      chk("R10 n flag", 32'(res_n), 32'(exp_n));
      chk("R3 read count", 32'(op_rd), 32'(exp_rd));
      chk("R3 first byte", 32'(op_first), 32'(exp_first));
      chk("R9 write count", 32'(op_wr), 32'(exp_wr));
      chk("R9 order", 32'(ord_err - ord_base), 32'd0);
      chk("R12 hold", 32'(hold_err - hold_base), 32'd0);
      bad = 0;
      for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) bad++;
      chk({tag, " memory"}, 32'(bad), 32'd0);
   endtask

   task automatic run_op(input string tag, input logic [2:0] op, input int base,
                         input int ofs, input int len, input logic [31:0] val);
      issue(op, base, ofs, len, val);
      finish_op(tag);
   endtask

   task automatic t_reset;
      chk("R11 reset ready", 32'(cmd_ready), 32'd1);
      chk("R11 reset done", 32'(done), 32'd0);
      chk("R11 reset mem_valid", 32'(mem_valid), 32'd0);
   endtask

   task automatic t_len_zero;
      run_op("R1 len0 extract", OP_EXTU, 20, 0, 0, 0);
      run_op("R1 len0 signed", OP_EXTS, 21, 3, 0, 0);
   endtask

   task automatic t_neg_offset;
      run_op("R2 negative offset", OP_EXTU, 20, -3, 6, 0);
      run_op("R2 far negative", OP_EXTS, 30, -45, 13, 0);
   endtask

   task automatic t_bit_order;
      run_op("R4 first bit", OP_EXTU, 12, 0, 1, 0);
      run_op("R4 byte crossing", OP_EXTU, 12, 6, 4, 0);
   endtask

   task automatic t_extract;
      run_op("R5 signed", OP_EXTS, 16, 5, 7, 0);
      run_op("R5 unsigned", OP_EXTU, 16, 5, 7, 0);
      run_op("R5 signed wide", OP_EXTS, 8, 9, 17, 0);
   endtask

   task automatic t_insert;
      run_op("R6 insert", OP_INS, 26, 13, 11, 32'hFFFF_F5A5);
      run_op("R6 insert full", OP_INS, 40, 5, 0, 32'h8123_4567);
   endtask

   task automatic t_modify;
      run_op("R7 change five bytes", OP_CHG, 24, 7, 0, 0);
      run_op("R7 clear", OP_CLR, 34, -17, 12, 0);
      run_op("R7 set", OP_SET, 44, -2, 9, 0);
   endtask

   task automatic t_ffo;
      run_op("R8 ffo", OP_FFO, 20, 4, 20, 0);
      run_op("R7 clear for ffo", OP_CLR, 50, -20, 14, 0);
      run_op("R8 ffo zero field", OP_FFO, 50, -20, 14, 0);
   endtask

   task automatic t_stall;
      stall_en = 1'b1;
      run_op("R12 stalled insert", OP_INS, 10, 3, 19, 32'h0005_A5C3);
      run_op("R12 stalled extract", OP_EXTU, 10, 3, 19, 0);
      stall_en = 1'b0;
   endtask

   task automatic t_back_to_back;
      issue(OP_SET, 36, 4, 10, 0);
      finish_op("R11 first of pair");
      // done is high at this point: present the next command now
      issue(OP_EXTU, 36, 2, 14, 0);
      chk("R11 accepted in done cycle busy", 32'(cmd_ready), 32'd0);
      chk("R11 done dropped", 32'(done), 32'd0);
      finish_op("R11 second of pair");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_len_zero();
      t_neg_offset();
      t_bit_order();
      t_extract();
      t_insert();
      t_modify();
      t_ffo();
      t_stall();
      t_back_to_back();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

endmodule